// File: doc/BRIEF.md
# Floating-Point Opcode History Registers

This block keeps a short history of floating-point instruction opcodes as they move through a pipeline. It holds three 11-bit records. The first is the opcode most recently fetched ahead of execution. The second is the last non-control opcode that actually executed. The third is the last non-control opcode that raised an exception.

Each record is built from the two opcode bytes the caller supplies. The low three bits of the first byte become the top three bits of the record, and the whole second byte becomes the low eight bits. The fault record can also be loaded through a write port. The environment-save opcode field shows the fault record, so a save that follows a write reports the written value.

The caller decodes the instruction set itself. It supplies the control-instruction flag and a flag for a wait instruction fetched on its own. The block uses these flags and looks at nothing else in the opcode.

Top module: `fpuOpHistory`

## Requirements
- R1: While reset is active and on the first cycle after it, all three records and the environment-save field read zero.
- R2: A loaded record is packed as bits 10:8 = first byte bits 2:0 and bits 7:0 = second byte. For example, bytes 0xDD and 0xE1 give 0x5E1.
- R3: Every cycle with `pfValid` high loads the prefetch record, visible one cycle later. Execute, control and exception activity never change it.
- R4: A prefetch with `pfIsWait` high records 0x09B whatever opcode bytes are presented.
- R5: The execute record loads the packed execute bytes only when `exValid` is high and `exIsControl` is low. Otherwise it holds its value.
- R6: The fault record captures the packed execute bytes when `exValid`, `exFault` are high and `exIsControl` is low. If `exFault` comes with a control instruction, or without `exValid`, the fault record is not changed.
- R7: With `wrEn` high and no capture in that cycle, the fault record takes `wrData` one cycle later.
- R8: When a write and a fault capture happen in the same cycle, the capture wins and the written value is discarded.
- R9: `envOpcode` always equals the fault record, so it shows a written value from the cycle after the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Synchronous reset, active low |
| pfValid | input | 1 | A floating-point opcode was prefetched |
| pfIsWait | input | 1 | The prefetched instruction is a wait on its own |
| pfByte0 | input | 8 | First byte of the prefetched opcode |
| pfByte1 | input | 8 | Second byte of the prefetched opcode |
| exValid | input | 1 | A floating-point instruction executes |
| exIsControl | input | 1 | The executing instruction is a control instruction |
| exFault | input | 1 | The executing instruction raised an exception |
| exByte0 | input | 8 | First byte of the executing opcode |
| exByte1 | input | 8 | Second byte of the executing opcode |
| wrEn | input | 1 | Write the fault record |
| wrData | input | 11 | Value to write into the fault record |
| pfOpcode | output | 11 | Prefetch record |
| exOpcode | output | 11 | Execute record |
| faultOpcode | output | 11 | Fault record |
| envOpcode | output | 11 | Opcode field of the environment-save image |

## Verification
The bench builds the block with its default wait byte of 0x9B and 11-bit records. This makes the fixed wait code 0x09B, and the R2 packing example, checkable as literal values. Random traffic sets each event flag often enough that prefetch, execute, fault and write land in the same cycle in every combination, so the capture-over-write priority and the rule that a control instruction ignores a fault are both reached many times. Directed steps pin the wait code, the packing example and the write-then-save sequence.

// File: rtl/fpuOpPkg.sv
package fpuOpPkg;
  localparam int KEEP_W = 3;
  localparam int BYTE_W = 8;
  localparam int OP_W   = KEEP_W + BYTE_W;
  localparam int SLOTS  = 3;

  typedef logic [OP_W-1:0]   opcode_t;
  typedef logic [BYTE_W-1:0] opByte_t;

  typedef enum logic [1:0] {
    SLOT_PF    = 2'd0,
    SLOT_EX    = 2'd1,
    SLOT_FAULT = 2'd2
  } slot_e;

  typedef struct packed {
    logic ldPf;
    logic pfWait;
    logic ldEx;
    logic ldFault;
    logic ldWrite;
  } strobes_t;

  function automatic opcode_t packOp(input opByte_t first, input opByte_t second);
    return {first[KEEP_W-1:0], second};
  endfunction
endpackage

// File: rtl/fpuOpCtrl.sv
module fpuOpCtrl
  import fpuOpPkg::*;
(
  input  logic     clk,
  input  logic     rstN,
  input  logic     pfValid,
  input  logic     pfIsWait,
  input  logic     exValid,
  input  logic     exIsControl,
  input  logic     exFault,
  input  logic     wrEn,
  output strobes_t ctl
);
  logic exRetire;

  always_comb begin
    exRetire    = exValid && !exIsControl;
    ctl.ldPf    = pfValid;
    ctl.pfWait  = pfValid && pfIsWait;
    ctl.ldEx    = exRetire;
    ctl.ldFault = exRetire && exFault;
    ctl.ldWrite = wrEn && !(exRetire && exFault);
  end

  // R5
  ctlNoCtrlExec_chk: assert property (@(posedge clk) disable iff (!rstN)
    (exValid && exIsControl) |-> !ctl.ldEx && !ctl.ldFault);

  // R8
  ctlOneFaultSrc_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(ctl.ldFault && ctl.ldWrite));
endmodule

// File: rtl/fpuOpData.sv
module fpuOpData
  import fpuOpPkg::*;
#(
  parameter opByte_t WAIT_BYTE = 8'h9B
) (
  input  logic     clk,
  input  logic     rstN,
  input  strobes_t ctl,
  input  opByte_t  pfByte0,
  input  opByte_t  pfByte1,
  input  opByte_t  exByte0,
  input  opByte_t  exByte1,
  input  opcode_t  wrData,
  output opcode_t  pfOpcode,
  output opcode_t  exOpcode,
  output opcode_t  faultOpcode
);
  localparam opcode_t WAIT_CODE = opcode_t'(WAIT_BYTE);

  opcode_t slotNext [SLOTS];
  logic    slotLoad [SLOTS];
  opcode_t slotReg  [SLOTS];
  opcode_t exPacked;

  always_comb begin
    exPacked                  = packOp(exByte0, exByte1);
    slotNext[int'(SLOT_PF)]   = ctl.pfWait ? WAIT_CODE : packOp(pfByte0, pfByte1);
    slotLoad[int'(SLOT_PF)]   = ctl.ldPf;
    slotNext[int'(SLOT_EX)]   = exPacked;
    slotLoad[int'(SLOT_EX)]   = ctl.ldEx;
    slotNext[int'(SLOT_FAULT)] = ctl.ldFault ? exPacked : wrData;
    slotLoad[int'(SLOT_FAULT)] = ctl.ldFault || ctl.ldWrite;
  end

  for (genvar g = 0; g < SLOTS; g++) begin : gSlot
    always_ff @(posedge clk) begin
      if (!rstN)            slotReg[g] <= '0;
      else if (slotLoad[g]) slotReg[g] <= slotNext[g];
    end
  end

  assign pfOpcode    = slotReg[int'(SLOT_PF)];
  assign exOpcode    = slotReg[int'(SLOT_EX)];
  assign faultOpcode = slotReg[int'(SLOT_FAULT)];

  // R3
  pfLoad_chk: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.ldPf && !ctl.pfWait) |=> pfOpcode == {$past(pfByte0[KEEP_W-1:0]), $past(pfByte1)});

  // R4
  pfWaitCode_chk: assert property (@(posedge clk) disable iff (!rstN)
    ctl.pfWait |=> pfOpcode == WAIT_CODE);

  // R5
  exHold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !ctl.ldEx |=> $stable(exOpcode));

  // R3
  pfHold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !ctl.ldPf |=> $stable(pfOpcode));
endmodule

// File: rtl/fpuOpHistory.sv
module fpuOpHistory
  import fpuOpPkg::*;
#(
  parameter logic [7:0] WAIT_BYTE = 8'h9B
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        pfValid,
  input  logic        pfIsWait,
  input  logic [7:0]  pfByte0,
  input  logic [7:0]  pfByte1,
  input  logic        exValid,
  input  logic        exIsControl,
  input  logic        exFault,
  input  logic [7:0]  exByte0,
  input  logic [7:0]  exByte1,
  input  logic        wrEn,
  input  logic [10:0] wrData,
  output logic [10:0] pfOpcode,
  output logic [10:0] exOpcode,
  output logic [10:0] faultOpcode,
  output logic [10:0] envOpcode
);
  strobes_t ctl;

  fpuOpCtrl i_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .pfValid    (pfValid),
    .pfIsWait   (pfIsWait),
    .exValid    (exValid),
    .exIsControl(exIsControl),
    .exFault    (exFault),
    .wrEn       (wrEn),
    .ctl        (ctl)
  );

  fpuOpData #(.WAIT_BYTE(WAIT_BYTE)) i_data (
    .clk        (clk),
    .rstN       (rstN),
    .ctl        (ctl),
    .pfByte0    (pfByte0),
    .pfByte1    (pfByte1),
    .exByte0    (exByte0),
    .exByte1    (exByte1),
    .wrData     (wrData),
    .pfOpcode   (pfOpcode),
    .exOpcode   (exOpcode),
    .faultOpcode(faultOpcode)
  );

  assign envOpcode = faultOpcode;

  // R8
  captureBeatsWrite_chk: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && exValid && exFault && !exIsControl)
      |=> faultOpcode == {$past(exByte0[2:0]), $past(exByte1)});

  // R6
  ctrlFaultIgnored_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!wrEn && !(exValid && !exIsControl)) |=> $stable(faultOpcode));

  // R7
  writeLands_chk: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && !(exValid && exFault && !exIsControl)) |=> envOpcode == $past(wrData));
endmodule

// File: tb/test_fpuOpHistory.sv
module test_fpuOpHistory;
  localparam int CLK_PERIOD = 10;
  localparam int RAND_CYCLES = 3000;
  localparam int WATCHDOG = 20000;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic pfValid = 0, pfIsWait = 0, exValid = 0, exIsControl = 0, exFault = 0, wrEn = 0;
  logic [7:0] pfByte0 = 0, pfByte1 = 0, exByte0 = 0, exByte1 = 0;
  logic [10:0] wrData = 0;
  logic [10:0] pfOpcode, exOpcode, faultOpcode, envOpcode;

  int vectors = 0;
  int fails = 0;
  int cycles = 0;
  bit done = 0;

  logic [10:0] mPf = 0, mEx = 0, mFault = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  fpuOpHistory i_fpuOpHistory (
    .clk(clk), .rstN(rstN),
    .pfValid(pfValid), .pfIsWait(pfIsWait), .pfByte0(pfByte0), .pfByte1(pfByte1),
    .exValid(exValid), .exIsControl(exIsControl), .exFault(exFault),
    .exByte0(exByte0), .exByte1(exByte1),
    .wrEn(wrEn), .wrData(wrData),
    .pfOpcode(pfOpcode), .exOpcode(exOpcode), .faultOpcode(faultOpcode), .envOpcode(envOpcode)
  );

  task automatic chk(input string tag, input logic [10:0] got, input logic [10:0] exp);
    vectors++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s actual=%03h expected=%03h at cycle %0d", tag, got, exp, cycles);
    end
  endtask

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  endtask

  // Behavioural reference: computes next model state from inputs in this cycle.
  function automatic logic [10:0] joinBytes(input logic [7:0] a, input logic [7:0] b);
    logic [10:0] r;
    r = 11'(b) + 11'(int'(a % 8) * 256);
    return r;
  endfunction

  task automatic advance();
    logic [10:0] nPf, nEx, nFault;
    nPf = mPf; nEx = mEx; nFault = mFault;
    if (pfValid) nPf = pfIsWait ? 11'h09B : joinBytes(pfByte0, pfByte1);
    if (exValid && !exIsControl) nEx = joinBytes(exByte0, exByte1);
    if (wrEn) nFault = wrData;
    if (exValid && !exIsControl && exFault) nFault = joinBytes(exByte0, exByte1);
    @(posedge clk);
    cycles++;
    mPf = nPf; mEx = nEx; mFault = nFault;
    #1;
    chk("R3 prefetch record", pfOpcode, mPf);
    chk("R5 execute record", exOpcode, mEx);
    chk("R6 fault record", faultOpcode, mFault);
    chk("R9 env field", envOpcode, mFault);
    @(negedge clk);
  endtask

  task automatic idle();
    pfValid = 0; pfIsWait = 0; exValid = 0; exIsControl = 0; exFault = 0; wrEn = 0;
  endtask

  initial begin
    while (!done) begin
      @(posedge clk);
      if (cycles > WATCHDOG) begin
        fails++;
        $display("FAIL watchdog expired actual=%0d expected<=%0d", cycles, WATCHDOG);
        summary();
      end
    end
  end

  initial begin
    idle();
    repeat (3) @(negedge clk);
    // R1: reset state
    chk("R1 reset pf", pfOpcode, 11'h000);
    chk("R1 reset ex", exOpcode, 11'h000);
    chk("R1 reset fault", faultOpcode, 11'h000);
    rstN = 1'b1;
    advance();
    chk("R1 after reset env", envOpcode, 11'h000);

    // R2: packing DD E1 -> 5E1 in prefetch and execute
    pfValid = 1; pfByte0 = 8'hDD; pfByte1 = 8'hE1;
    exValid = 1; exByte0 = 8'hDD; exByte1 = 8'hE1;
    advance();
    chk("R2 packing pf", pfOpcode, 11'h5E1);
    chk("R2 packing ex", exOpcode, 11'h5E1);
    idle();

    // R4: wait alone -> 09B
    pfValid = 1; pfIsWait = 1; pfByte0 = 8'hD9; pfByte1 = 8'hC0;
    advance();
    chk("R4 wait code", pfOpcode, 11'h09B);
    idle();

    // R5/R6: control instruction with fault changes neither record
    exValid = 1; exIsControl = 1; exFault = 1; exByte0 = 8'hD9; exByte1 = 8'h30;
    advance();
    chk("R5 control keeps execute", exOpcode, 11'h5E1);
    chk("R6 control fault ignored", faultOpcode, 11'h000);
    idle();
    // R6: fault without exValid ignored
    exFault = 1; exByte0 = 8'hDF; exByte1 = 8'h11;
    advance();
    chk("R6 fault without execute", faultOpcode, 11'h000);
    idle();

    // R7/R9: write then env shows it next cycle
    wrEn = 1; wrData = 11'h3A5;
    advance();
    chk("R7 write fault", faultOpcode, 11'h3A5);
    chk("R9 env after write", envOpcode, 11'h3A5);
    idle();

    // R8: capture beats write in the same cycle
    wrEn = 1; wrData = 11'h7FF; exValid = 1; exFault = 1; exByte0 = 8'hDA; exByte1 = 8'h44;
    advance();
    chk("R8 capture wins", faultOpcode, 11'h244);
    idle();

    // Random traffic, reference compared every clock (R3 R5 R6 R7 R8 R9)
    for (int i = 0; i < RAND_CYCLES; i++) begin
      pfValid = ($urandom % 2) == 0;
      pfIsWait = ($urandom % 5) == 0;
      pfByte0 = 8'($urandom); pfByte1 = 8'($urandom);
      exValid = ($urandom % 3) != 0;
      exIsControl = ($urandom % 4) == 0;
      exFault = ($urandom % 3) == 0;
      exByte0 = 8'($urandom); exByte1 = 8'($urandom);
      wrEn = ($urandom % 4) == 0;
      wrData = 11'($urandom);
      advance();
    end
    idle();
    done = 1;
    summary();
  end
endmodule